// File: doc/BRIEF.md
# Length-Decoded Serial Configuration Port

This block is a three-wire serial write port that holds three configuration registers: an 8-bit control word, a 16-bit divider word and a 24-bit main word. The frame carries no address or steering bits. The number of shift-clock rising edges counted between the falling and the rising edge of the active-low enable selects the register that is written. Bits arrive most significant first. A target register changes only when the enable returns high, so a frame that is still being shifted never disturbs a live setting.

The divider word is split. Its three upper bits take effect as soon as a 16-bit frame commits. Its thirteen lower bits go to a staging buffer. They reach the active divider field later, in one of two ways: a 24-bit frame copies them in the same cycle that it writes the main word, or an enable low pulse with no clock edges copies them alone. A serial data output shows the far end of the shift register, and it moves only on falling edges of the shift clock. The two top bits of the main word decode a configurable output. When both bits are set, a select flag for the reference divider pulse is raised.

The shift clock and the enable are sampled in the system clock domain and treated as synchronous strobes. Reset is synchronous and active low.

Top module: `srp_port`

## Requirements
- R1: Serial data is sampled on each rising edge of the shift clock and enters most significant bit first. The first bit of a frame lands in the top bit of the target field.
- R2: A frame of exactly 8 shift-clock rising edges loads `cfg_o` with the 8 bits received.
- R3: A frame of exactly 16 rising edges sets `rmode_o` to bits 15..13 of the frame at once. Bits 12..0 go to the staging buffer, and `rdiv_o` does not change.
- R4: A frame of exactly 24 rising edges loads `aword_o` with the 24 bits received. In the same cycle it copies the staging buffer into `rdiv_o`.
- R5: No output register changes while a frame is being shifted. Registers update only when the enable rises.
- R6: An enable low pulse with zero shift-clock rising edges copies the staging buffer into `rdiv_o` and leaves every other register unchanged.
- R7: A frame whose count is not 0, 8, 16 or 24 changes no register. This includes counts above 24, where the counter saturates.
- R8: While the enable is high, shift-clock activity is ignored and the bit counter and shift register stay cleared, so the next frame starts from an empty state.
- R9: `sdo_o` changes only on a falling edge of the shift clock, where it takes bit 23 of the shift register. After the 24th falling edge of a frame it shows that frame's first bit. It is 0 while the enable is high.
- R10: `refsel_o` is 1 exactly when bits 23 and 22 of `aword_o` are both 1.
- R11: Reset clears every register, both divider stages and `sdo_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock, sampled as a strobe |
| sdi_i | input | 1 | Serial data in, MSB first |
| sen_n_i | input | 1 | Active-low frame enable |
| cfg_o | output | 8 | 8-bit control register |
| rmode_o | output | 3 | Upper divider bits, applied immediately |
| rdiv_o | output | 13 | Active (second-stage) divider field |
| aword_o | output | 24 | 24-bit main register |
| refsel_o | output | 1 | Configurable output selects reference pulse |
| sdo_o | output | 1 | Serial data out, moves on shift-clock fall |

## Verification
The hardest state to reach is a staged divider value that differs from the active one, followed by a commit that moves only the staged part. The bench writes a 16-bit frame and checks that `rdiv_o` has kept its old value. It then commits the staged bits once through a bare enable pulse and once through a 24-bit frame, and confirms that only the intended fields change. The serial output is checked edge by edge across the 23rd and 24th bits to confirm that it moves on the falling edge and never on the rising edge.

// File: rtl/srp_pkg.sv
package srp_pkg;
    localparam int CFG_W = 8;
    localparam int RB_W  = 16;
    localparam int RLO_W = 13;
    localparam int RHI_W = RB_W - RLO_W;
    localparam int AW_W  = 24;
    localparam int CNT_W = $clog2(AW_W + 2);

    typedef struct packed {
        logic             sclk;
        logic             sen_n;
        logic [CNT_W-1:0] cnt;
        logic [AW_W-1:0]  shreg;
        logic             sdo;
    } shf_t;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [RHI_W-1:0] rhi;
        logic [RLO_W-1:0] rlo1;
        logic [RLO_W-1:0] rlo2;
        logic [AW_W-1:0]  aw;
    } rf_t;
endpackage

// File: rtl/srp_shifter.sv
module srp_shifter
    import srp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             sdi_i,
    input  logic             sen_n_i,
    output logic             commit_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [AW_W-1:0]  data_o,
    output logic             sdo_o
);
    shf_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        st_d       = st_q;
        st_d.sclk  = sclk_i;
        st_d.sen_n = sen_n_i;
        rise       = sclk_i & ~st_q.sclk;
        fall       = ~sclk_i & st_q.sclk;
        if (sen_n_i) begin
            st_d.cnt   = '0;
            st_d.shreg = '0;
            st_d.sdo   = 1'b0;
        end else begin
            if (rise) begin
                st_d.shreg = {st_q.shreg[AW_W-2:0], sdi_i};
                if (st_q.cnt != {CNT_W{1'b1}})
                    st_d.cnt = st_q.cnt + CNT_W'(1);
            end
            if (fall)
                st_d.sdo = st_q.shreg[AW_W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.sen_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_o = sen_n_i & ~st_q.sen_n;
    assign cnt_o    = st_q.cnt;
    assign data_o   = st_q.shreg;
    assign sdo_o    = st_q.sdo;

    AST_SDO_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!(~sclk_i & st_q.sclk) && !sen_n_i) |=> $stable(sdo_o)); // R9
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sen_n_i |=> (cnt_o == '0 && data_o == '0)); // R8
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile
    import srp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [AW_W-1:0]  data_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic [RHI_W-1:0] rhi_o,
    output logic [RLO_W-1:0] rlo_o,
    output logic [AW_W-1:0]  aw_o
);
    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (commit_i) begin
            if (cnt_i == '0) begin
                rf_d.rlo2 = rf_q.rlo1;
            end else if (cnt_i == CNT_W'(CFG_W)) begin
                rf_d.cfg = data_i[CFG_W-1:0];
            end else if (cnt_i == CNT_W'(RB_W)) begin
                rf_d.rhi  = data_i[RB_W-1:RLO_W];
                rf_d.rlo1 = data_i[RLO_W-1:0];
            end else if (cnt_i == CNT_W'(AW_W)) begin
                rf_d.aw   = data_i;
                rf_d.rlo2 = rf_q.rlo1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign cfg_o = rf_q.cfg;
    assign rhi_o = rf_q.rhi;
    assign rlo_o = rf_q.rlo2;
    assign aw_o  = rf_q.aw;

    AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(cfg_o) && $stable(aw_o) && $stable(rlo_o))); // R5
    AST_BAD_LEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && cnt_i != '0 && cnt_i != CNT_W'(CFG_W) && cnt_i != CNT_W'(RB_W)
         && cnt_i != CNT_W'(AW_W)) |=> ($stable(cfg_o) && $stable(aw_o) && $stable(rlo_o) && $stable(rhi_o))); // R7
    AST_AWORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && cnt_i == CNT_W'(AW_W)) |=> (aw_o == $past(data_i))); // R4
    AST_R16_NO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && cnt_i == CNT_W'(RB_W)) |=> $stable(rlo_o)); // R3
endmodule

// File: rtl/srp_port.sv
module srp_port
    import srp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             sdi_i,
    input  logic             sen_n_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic [RHI_W-1:0] rmode_o,
    output logic [RLO_W-1:0] rdiv_o,
    output logic [AW_W-1:0]  aword_o,
    output logic             refsel_o,
    output logic             sdo_o
);
    logic             commit;
    logic [CNT_W-1:0] cnt;
    logic [AW_W-1:0]  data;

    srp_shifter u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (sclk_i),
        .sdi_i    (sdi_i),
        .sen_n_i  (sen_n_i),
        .commit_o (commit),
        .cnt_o    (cnt),
        .data_o   (data),
        .sdo_o    (sdo_o)
    );

    srp_regfile u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .cnt_i    (cnt),
        .data_i   (data),
        .cfg_o    (cfg_o),
        .rhi_o    (rmode_o),
        .rlo_o    (rdiv_o),
        .aw_o     (aword_o)
    );

    assign refsel_o = aword_o[AW_W-1] & aword_o[AW_W-2];

    AST_REFSEL_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        refsel_o == (aword_o[AW_W-1:AW_W-2] == 2'b11)); // R10
endmodule

// File: tb/sim_srp_port.sv
module sim_srp_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sen_n = 1'b1;
    logic [7:0]  cfg;
    logic [2:0]  rmode;
    logic [12:0] rdiv;
    logic [23:0] aword;
    logic        refsel;
    logic        sdo;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0]  e_cfg = '0;
    logic [2:0]  e_rmode = '0;
    logic [12:0] e_stage = '0;
    logic [12:0] e_rdiv = '0;
    logic [23:0] e_aword = '0;

    always #10 clk = ~clk;

    srp_port u0 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .sen_n_i(sen_n),
        .cfg_o(cfg), .rmode_o(rmode), .rdiv_o(rdiv), .aword_o(aword),
        .refsel_o(refsel), .sdo_o(sdo)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_all(string req);
        chk({req, " cfg"}, 32'(cfg), 32'(e_cfg));
        chk({req, " rmode"}, 32'(rmode), 32'(e_rmode));
        chk({req, " rdiv"}, 32'(rdiv), 32'(e_rdiv));
        chk({req, " aword"}, 32'(aword), 32'(e_aword));
        chk({req, " refsel"}, 32'(refsel), 32'(e_aword[23] & e_aword[22]));
    endtask

    task automatic begin_f();
        sen_n = 1'b0; wt(2);
    endtask

    task automatic end_f();
        sen_n = 1'b1; wt(3);
    endtask

    task automatic bits(int n, logic [31:0] v);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = v[i];
            sclk = 1'b1; wt(2);
            sclk = 1'b0; wt(2);
        end
    endtask

    task automatic frame(int n, logic [31:0] v);
        begin_f(); bits(n, v); end_f();
    endtask

    task automatic t_reset();
        wt(3); rst_n = 1'b1; wt(2);
        chk_all("R11 reset");
        chk("R11 sdo", 32'(sdo), 0);
    endtask

    task automatic t_cfg8();
        frame(8, 32'hA5);
        e_cfg = 8'hA5;
        chk_all("R2 8-clock frame");
        chk("R1 msb first", 32'(cfg[7]), 1);
        frame(8, 32'h3C);
        e_cfg = 8'h3C;
        chk_all("R2 second 8-clock frame");
    endtask

    task automatic t_mid_frame();
        begin_f();
        bits(4, 32'h9);
        chk_all("R5 mid-frame hold");
        bits(4, 32'h6);
        chk_all("R5 before enable rise");
        end_f();
        e_cfg = 8'h96;
        chk_all("R5 after enable rise");
    endtask

    task automatic t_r16();
        frame(16, 32'hB123);
        e_rmode = 3'b101;
        e_stage = 13'h1123;
        chk_all("R3 16-clock frame staged");
    endtask

    task automatic t_zero_clk();
        frame(0, 32'h0);
        e_rdiv = e_stage;
        chk_all("R6 bare enable pulse");
    endtask

    task automatic t_a24_sdo(logic [23:0] v, logic [15:0] rv);
        frame(16, 32'(rv));
        e_rmode = rv[15:13];
        e_stage = rv[12:0];
        chk_all("R3 staged before 24-bit frame");
        begin_f();
        bits(23, 32'(v >> 1));
        chk("R9 sdo before 24th fall", 32'(sdo), 0);
        sdi = v[0];
        sclk = 1'b1; wt(2);
        chk("R9 sdo unchanged on rise", 32'(sdo), 0);
        sclk = 1'b0; wt(2);
        chk("R9 sdo after 24th fall", 32'(sdo), 32'(v[23]));
        end_f();
        chk("R9 sdo idle", 32'(sdo), 0);
        e_aword = v;
        e_rdiv = e_stage;
        chk_all("R4 R10 24-bit frame");
    endtask

    task automatic t_bad_len();
        frame(12, 32'hFFF);
        chk_all("R7 12-clock frame ignored");
        frame(40, 32'hFFFF_FFFF);
        chk_all("R7 40-clock frame ignored");
        frame(15, 32'h7FFF);
        chk_all("R7 15-clock frame ignored");
    endtask

    task automatic t_idle();
        sdi = 1'b1;
        for (int i = 0; i < 10; i++) begin
            sclk = 1'b1; wt(2);
            sclk = 1'b0; wt(2);
        end
        chk_all("R8 idle clocks ignored");
        frame(8, 32'h5A);
        e_cfg = 8'h5A;
        chk_all("R8 frame after idle clocks");
    endtask

    initial begin
        t_reset();
        t_cfg8();
        t_mid_frame();
        t_r16();
        t_zero_clk();
        t_a24_sdo(24'hC3_5A7E, 16'h4ABC);
        t_a24_sdo(24'h41_0001, 16'hE001);
        t_bad_len();
        t_idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule